// File: doc/BRIEF.md
# Programmable 128 Hz Tick Generator

This block produces the 128 Hz timebase of a realtime clock from a fast reference clock of nearly any frequency. Software programs a 32-bit configuration word that holds a 19-bit period count and a half-rate flag. The divider counts reference cycles against that count and raises its tick output for one reference cycle at each period boundary.

There are two divide modes. When the reference is a whole multiple of 128 Hz, the period count is the reference frequency over 128, and each count period gives one tick. When the reference is a multiple of 64 Hz but not of 128 Hz, the half-rate flag is set and the count is the reference frequency over 64. The divider then splits each count period into two segments of floor(v/2) and ceil(v/2) cycles, so the average rate is exactly 128 Hz even when the count is odd. A clock-source select input picks a bypass, in which an already-correct 128 Hz pulse from elsewhere goes straight to the output and the divider rests.

Top module: `tick128_gen`

## Requirements
- R1: After reset the configuration word reads 0 and no tick is produced. The read data always shows the half-rate flag at bit 31 and the period count at bits 18:0, as last written.
- R2: Bits 30 to 19 of the read data are always 0, whatever value was written to them.
- R3: With the half-rate flag at 0 and a count v of 2 or more, counting k from 0 at the first cycle after the write, the tick is high exactly in the cycles where k mod v equals v-1.
- R4: With the half-rate flag at 1 and a count v of 2 or more, with h = floor(v/2), the tick is high exactly in the cycles where k mod v equals h-1 or v-1.
- R5: While the source select is 00, the tick output equals the alternate 128 Hz input in every cycle.
- R6: A count of 0 or 1 produces no tick while the source select is not 00.
- R7: Every write restarts the period count and the segment phase, so the tick pattern of R3/R4 is measured from the write, whatever the state was before it.
- R8: Leaving the bypass starts a clean period: k counts from 0 in the first cycle in which the source select is not 00.
- R9: The 10 MHz setting (count 0x1312D, flag 0) gives its first tick 78125 cycles after the write. The settings 0x29F63 and 0x31975 with flag 1 and 0x16E36 with flag 0 read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Current configuration word |
| src_sel | input | 2 | Clock-source select; 00 picks the bypass |
| alt_tick | input | 1 | Alternate 128 Hz pulse used in bypass |
| tick_out | output | 1 | 128 Hz tick, one reference cycle wide |

## Verification
The assertions check in every cycle that the reserved bits read 0, that the bypass output copies the alternate input, that a count below 2 keeps the tick low, that the counter stays below the current segment length, and that a write or the bypass returns the counter to zero on the next cycle. The exact position of each tick, the split of odd counts into floor and ceiling halves, and the 10 MHz period can only be shown by the bench. It sweeps every small count in both modes and compares the tick in each cycle with a pattern it computes from the count.

// File: rtl/tick128_pkg.sv
package tick128_pkg;

  parameter int unsigned CMP_W  = 19;
  parameter int unsigned WORD_W = 32;
  localparam int unsigned FLAG_POS = WORD_W - 1;
  localparam int unsigned RSVD_W   = WORD_W - 1 - CMP_W;

  typedef logic [CMP_W-1:0] cmp_t;

  // Divider runs only for counts that give a segment of at least one cycle.
  function automatic logic div_ok(cmp_t v);
    return v > cmp_t'(1);
  endfunction

  // Length of the current segment: full count in normal mode, the floor
  // half then the ceiling half in half-rate mode.
  function automatic cmp_t seg_len(cmp_t v, logic half_rate, logic second);
    cmp_t lo;
    lo = v >> 1;
    if (!half_rate) return v;
    if (!second)    return lo;
    return v - lo;
  endfunction

endpackage

// File: rtl/tick_cfg_reg.sv
module tick_cfg_reg
  import tick128_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output cmp_t              cmp,
  output logic              half_rate,
  output logic [WORD_W-1:0] rdata
);

  cmp_t cmp_q;
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else if (we) begin
      cmp_q  <= wdata[CMP_W-1:0];
      flag_q <= wdata[FLAG_POS];
    end
  end

  logic unused_rsvd;
  assign unused_rsvd = ^wdata[FLAG_POS-1:CMP_W];

  assign cmp       = cmp_q;
  assign half_rate = flag_q;
  assign rdata     = {flag_q, {RSVD_W{1'b0}}, cmp_q};

endmodule

// File: rtl/tick_div_core.sv
module tick_div_core
  import tick128_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  cmp_t cmp,
  input  logic half_rate,
  output logic run,
  output cmp_t cnt,
  output cmp_t term,
  output logic wrap
);

  cmp_t cnt_q;
  logic phase_q;

  always_comb begin
    run  = div_ok(cmp);
    term = seg_len(cmp, half_rate, phase_q);
    wrap = run && !clr && (cnt_q == term - cmp_t'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (clr || !run) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      phase_q <= half_rate ? ~phase_q : 1'b0;
    end else begin
      cnt_q   <= cnt_q + cmp_t'(1);
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tick128_gen.sv
module tick128_gen
  import tick128_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic [1:0]        src_sel,
  input  logic              alt_tick,
  output logic              tick_out
);

  cmp_t cmp_w;
  logic half_w;
  logic bypass_w;
  logic clr_w;
  logic run_w;
  cmp_t cnt_w;
  cmp_t term_w;
  logic wrap_w;

  assign bypass_w = (src_sel == 2'b00);
  assign clr_w    = cfg_we || bypass_w;

  tick_cfg_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .wdata     (cfg_wdata),
    .cmp       (cmp_w),
    .half_rate (half_w),
    .rdata     (cfg_rdata)
  );

  tick_div_core u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr_w),
    .cmp       (cmp_w),
    .half_rate (half_w),
    .run       (run_w),
    .cnt       (cnt_w),
    .term      (term_w),
    .wrap      (wrap_w)
  );

  assign tick_out = bypass_w ? alt_tick : wrap_w;

endmodule

// File: rtl/tick128_chk.sv
module tick128_chk
  import tick128_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [WORD_W-1:0] cfg_rdata,
  input logic [1:0]        src_sel,
  input logic              alt_tick,
  input logic              tick_out,
  input logic              run,
  input cmp_t              cnt,
  input cmp_t              term
);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[FLAG_POS-1:CMP_W] == '0); // R2

  AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b00) |-> (tick_out == alt_tick)); // R5

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != 2'b00 && !run) |-> !tick_out); // R6

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < term)); // R3

  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cnt == '0)); // R7

  AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b00) |=> (cnt == '0)); // R8

endmodule

bind tick128_gen tick128_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_rdata (cfg_rdata),
  .src_sel   (src_sel),
  .alt_tick  (alt_tick),
  .tick_out  (tick_out),
  .run       (run_w),
  .cnt       (cnt_w),
  .term      (term_w)
);

// File: tb/tick128_gen_tb.sv
module tick128_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  src_sel = 2'b01;
  logic        alt_tick = 1'b0;
  logic        tick_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tick128_gen u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .src_sel   (src_sel),
    .alt_tick  (alt_tick),
    .tick_out  (tick_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected tick at cycle k after a restart, from the requirement text.
  function automatic bit exp_tick(int k, int v, bit hr);
    int p;
    int h;
    if (v < 2) return 1'b0;
    p = k % v;
    h = v / 2;
    if (hr) return (p == h - 1) || (p == v - 1);
    return p == v - 1;
  endfunction

  // Drive a write; returns at the negedge of cycle k = 0.
  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wdata = '0;
  endtask

  task automatic watch(input string req, input int v, input bit hr, input int ncyc);
    for (int k = 0; k < ncyc; k++) begin
      #1;
      check(req, {31'b0, tick_out}, {31'b0, exp_tick(k, v, hr)});
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset rdata", cfg_rdata, 32'h0);
    check("R1 reset tick", {31'b0, tick_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      #1;
      check("R1 no tick before write", {31'b0, tick_out}, 32'h0);
      @(negedge clk);
    end

    // R1 R2 readback and reserved bits
    write_cfg(32'hFFFF_FFFF);
    #1;
    check("R2 reserved ignored", cfg_rdata, 32'h8007_FFFF);
    write_cfg(32'h7FF8_0000);
    #1;
    check("R2 reserved only", cfg_rdata, 32'h0);
    write_cfg(32'h8000_0ABC);
    #1;
    check("R1 readback", cfg_rdata, 32'h8000_0ABC);

    // R9 vectors readback
    write_cfg(32'h8002_9F63);
    #1;
    check("R9 11MHz readback", cfg_rdata, 32'h8002_9F63);
    write_cfg(32'h0001_6E36);
    #1;
    check("R9 12MHz readback", cfg_rdata, 32'h0001_6E36);
    write_cfg(32'h8003_1975);
    #1;
    check("R9 13MHz readback", cfg_rdata, 32'h8003_1975);

    // R3 R4 R6 R7 sweep of small counts in both modes
    for (int hr = 0; hr < 2; hr++) begin
      for (int v = 0; v <= 20; v++) begin
        write_cfg({hr[0], 12'b0, 19'(v)});
        if (v < 2) watch("R6 idle count", v, hr[0], 40);
        else if (hr == 0) watch("R3 normal mode", v, 1'b0, 3 * v + 5);
        else watch("R4 half-rate mode", v, 1'b1, 3 * v + 5);
      end
    end

    // R7 write in mid period restarts
    write_cfg(32'h0000_0009);
    repeat (5) @(negedge clk);
    write_cfg(32'h8000_0007);
    watch("R7 restart after write", 7, 1'b1, 25);

    // R5 bypass and R8 restart on leaving it
    write_cfg(32'h0000_0006);
    repeat (3) @(negedge clk);
    src_sel = 2'b00;
    for (int k = 0; k < 16; k++) begin
      alt_tick = ((k % 3) == 1);
      #1;
      check("R5 bypass copy", {31'b0, tick_out}, {31'b0, alt_tick});
      @(negedge clk);
    end
    alt_tick = 1'b1;
    src_sel = 2'b10;
    watch("R8 leave bypass", 6, 1'b0, 20);
    alt_tick = 1'b0;
    src_sel = 2'b00;
    #1;
    check("R5 bypass low", {31'b0, tick_out}, 32'h0);
    @(negedge clk);
    src_sel = 2'b11;
    watch("R8 leave bypass sel 11", 6, 1'b0, 14);

    // R9 10 MHz period
    write_cfg(32'h0001_312D);
    watch("R9 10MHz period", 78125, 1'b0, 78126);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule